// File: doc/BRIEF.md
# Asynchronous Serial Channel with Error Stall

This block is one full-duplex asynchronous serial channel. Software reaches it over a byte-wide bus with five decoded registers: two control registers, a status register, a transmit holding register and a receive holding register. The transmitter turns a byte into a frame on `txd`. The frame has a low start bit, then 7 or 8 data bits sent least significant bit first, then an optional even or odd parity bit, then one or two high stop bits. The receiver takes frames from `rxd` the same way. It oversamples the line with an external baud tick that runs at sixteen times the bit rate.

A line error is a parity mismatch, a low stop bit or an overrun. Once one is flagged, the receiver drops every later frame until software writes control A with its error-reset bit at zero. That write clears all three error flags at once. A level interrupt request follows the receive-full flag when the receive interrupt enable is set. The request-to-send output is driven straight from a control bit. Some control bits are only stored and read back; they have no function in this block.

Top module: `ser_chan`

## Requirements
- R1: The registers decode at these offsets: control A at 0, control B at 2, status at 4, transmit holding at 6, receive holding at 8. Any other offset reads 0x00 and ignores writes. After reset, control A reads 0x64, control B reads 0x00 and status reads 0x02.
- R2: The status bits are: bit7 receive full, bit6 overrun, bit5 parity error, bit4 framing error, bit3 receive interrupt enable, bit1 transmit empty, bit0 transmit interrupt enable. Bit2 reads 0. Only bits 3 and 0 can be written.
- R3: A transmit frame is a low start bit, then the data LSB first, then the parity bit if control A bit1 is 1, then the stop bits, all high. Control A bit2 picks 8 data bits (1) or 7 (0). Control B bit4 picks odd parity (1) or even parity (0). Control A bit0 picks two stop bits (1) or one (0). Each bit lasts 16 baud ticks.
- R4: Writing offset 6 clears transmit empty. The flag sets again when the shifter takes the byte. While control A bit5 (transmit enable) is 0, `txd` stays high and a written byte waits.
- R5: The receiver confirms a start bit at its midpoint and samples every 16 ticks after that. A complete frame loads the receive register and sets receive full. Reading offset 8 returns the byte and clears receive full. In 7-bit mode, bit7 of the received byte reads 0.
- R6: A received parity bit that does not match sets the parity error flag. A low sample on any stop bit sets the framing error flag. In both cases the byte is still loaded.
- R7: If a frame completes while receive full is set, the overrun flag sets. The new byte is discarded and the held byte is kept.
- R8: While any of the three error flags is set, completed frames are dropped. The receive register and receive full do not change.
- R9: Writing control A with bit3 at 0 clears the overrun, parity and framing flags together. Writing it with bit3 at 1 leaves them unchanged.
- R10: `irq` is high one cycle after receive interrupt enable and receive full are both 1, and it is low otherwise.
- R11: `rts_n` equals control A bit4, so the line is high when the bit is 1.
- R12: While control A bit6 (receive enable) is 0, frames on `rxd` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; data appears next cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idles high |
| rts_n | output | 1 | Request-to-send, active low |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench goes after the error stall itself. It checks that a good frame arriving after a parity error leaves status and data untouched. A design that kept receiving would show receive full. It also checks that a control A write with bit3 set does not clear the flags, where a design decoding the whole byte would clear them too soon. Overrun is driven with two frames back to back and the first byte is read back, which exposes a design that overwrites the held byte. The bench also covers 7-bit frames carrying a high eighth bit, two-stop framing with parity in both senses, and a transmit held back by the enable bit. A wrong field position or parity sense shows up as a transmit frame that differs from the scoreboard entry.

// File: rtl/ser_chan_pkg.sv
package ser_chan_pkg;
  // register offsets decoded by the bus logic
  localparam int OFS_CA = 0;
  localparam int OFS_CB = 2;
  localparam int OFS_ST = 4;
  localparam int OFS_TD = 6;
  localparam int OFS_RD = 8;
  localparam int FRAME_MAX = 12;

  typedef struct packed {
    logic two_stop;
    logic par_en;
    logic eight;
    logic odd;
  } line_fmt_t;

  // parity bit to send, even sense makes the total count of ones even
  function automatic logic par_of(input logic [7:0] d, input line_fmt_t f);
    return (f.eight ? ^d : ^d[6:0]) ^ f.odd;
  endfunction

  // number of line bits in a frame, start bit included
  function automatic logic [3:0] frame_bits(input line_fmt_t f);
    return 4'd9 + {3'b0, f.eight} + {3'b0, f.par_en} + {3'b0, f.two_stop};
  endfunction

  // frame bits LSB first, unused upper positions left high (stop level)
  function automatic logic [FRAME_MAX-1:0] build_frame(input logic [7:0] d, input line_fmt_t f);
    logic [FRAME_MAX-1:0] v;
    v = '1;
    v[0] = 1'b0;
    v[7:1] = d[6:0];
    if (f.eight) begin
      v[8] = d[7];
      if (f.par_en) v[9] = par_of(d, f);
    end else if (f.par_en) begin
      v[8] = par_of(d, f);
    end
    return v;
  endfunction
endpackage

// File: rtl/ser_chan_regs.sv
module ser_chan_regs
  import ser_chan_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output line_fmt_t         fmt,
  output logic              rx_en,
  output logic              tx_en,
  output logic              rts_n,
  output logic              irq,
  output logic [7:0]        tdr,
  output logic              tdr_full,
  input  logic              tx_take,
  input  logic              rx_done,
  input  logic [7:0]        rx_data,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  output logic [7:0]        stat,
  output logic [7:0]        rdr,
  output logic              err_any
);
  logic [7:0] ctla, ctlb;
  logic rdrf, ovr, pe, fe, rie, tie, tdre;
  logic hit_ca, hit_cb, hit_st, hit_td, hit_rd, clr_err;
  logic [7:0] rd_mux;

  assign hit_ca = (bus_addr == ADDR_W'(OFS_CA));
  assign hit_cb = (bus_addr == ADDR_W'(OFS_CB));
  assign hit_st = (bus_addr == ADDR_W'(OFS_ST));
  assign hit_td = (bus_addr == ADDR_W'(OFS_TD));
  assign hit_rd = (bus_addr == ADDR_W'(OFS_RD));

  assign err_any = ovr | pe | fe;
  assign clr_err = bus_wr && hit_ca && !bus_wdata[3];
  assign stat    = {rdrf, ovr, pe, fe, rie, 1'b0, tdre, tie};

  assign fmt      = '{two_stop: ctla[0], par_en: ctla[1], eight: ctla[2], odd: ctlb[4]};
  assign rx_en    = ctla[6];
  assign tx_en    = ctla[5];
  assign rts_n    = ctla[4];
  assign tdr_full = !tdre;

  always_comb begin
    rd_mux = 8'h00;
    if (hit_ca) rd_mux = ctla;
    if (hit_cb) rd_mux = ctlb;
    if (hit_st) rd_mux = stat;
    if (hit_td) rd_mux = tdr;
    if (hit_rd) rd_mux = rdr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctla      <= 8'h64;
      ctlb      <= 8'h00;
      tdr       <= 8'h00;
      rdr       <= 8'h00;
      rdrf      <= 1'b0;
      ovr       <= 1'b0;
      pe        <= 1'b0;
      fe        <= 1'b0;
      rie       <= 1'b0;
      tie       <= 1'b0;
      tdre      <= 1'b1;
      bus_rdata <= 8'h00;
      irq       <= 1'b0;
    end else begin
      if (bus_wr && hit_ca) ctla <= bus_wdata;
      if (bus_wr && hit_cb) ctlb <= bus_wdata;
      if (bus_wr && hit_st) begin
        rie <= bus_wdata[3];
        tie <= bus_wdata[0];
      end
      if (bus_wr && hit_td) begin
        tdr  <= bus_wdata;
        tdre <= 1'b0;
      end else if (tx_take) begin
        tdre <= 1'b1;
      end
      if (bus_rd && hit_rd) rdrf <= 1'b0;
      if (clr_err) begin
        ovr <= 1'b0;
        pe  <= 1'b0;
        fe  <= 1'b0;
      end
      // a frame is taken only when no error flag was standing
      if (rx_done && !err_any) begin
        if (rdrf) begin
          ovr <= 1'b1;
        end else begin
          rdr  <= rx_data;
          rdrf <= 1'b1;
          pe   <= rx_perr;
          fe   <= rx_ferr;
        end
      end
      if (bus_rd) bus_rdata <= rd_mux;
      irq <= rie & rdrf;
    end
  end
endmodule

// File: rtl/ser_chan_tx.sv
module ser_chan_tx
  import ser_chan_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      tx_en,
  input  line_fmt_t fmt,
  input  logic [7:0] tdr,
  input  logic      tdr_full,
  output logic      take,
  output logic      busy,
  output logic      txd
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] TOP = CW'(OVS - 1);

  logic [FRAME_MAX-1:0] sh;
  logic [3:0]           left;
  logic [CW-1:0]        cnt;

  assign take = !busy && tx_en && tdr_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      txd  <= 1'b1;
      sh   <= '1;
      left <= 4'd0;
      cnt  <= '0;
    end else if (take) begin
      busy <= 1'b1;
      txd  <= 1'b0;
      sh   <= build_frame(tdr, fmt) >> 1;
      left <= frame_bits(fmt);
      cnt  <= '0;
    end else if (busy && tick) begin
      if (cnt == TOP) begin
        cnt <= '0;
        if (left == 4'd1) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          txd  <= sh[0];
          sh   <= {1'b1, sh[FRAME_MAX-1:1]};
          left <= left - 4'd1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ser_chan_rx.sv
module ser_chan_rx
  import ser_chan_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxd,
  input  logic       rx_en,
  input  line_fmt_t  fmt,
  output logic       done,
  output logic [7:0] data,
  output logic       perr,
  output logic       ferr
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] TOP = CW'(OVS - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} rx_state_t;

  rx_state_t     st;
  logic          s1, s2, s3;
  logic [CW-1:0] cnt;
  logic [3:0]    idx, last_idx, stop0;
  logic [10:0]   col, col_nx;
  line_fmt_t     fq;
  logic [7:0]    dat_nx;
  logic          pbit;

  always_comb begin
    col_nx      = col;
    col_nx[idx] = s2;
    stop0    = 4'd7 + {3'b0, fq.eight} + {3'b0, fq.par_en};
    last_idx = stop0 + {3'b0, fq.two_stop};
    dat_nx   = fq.eight ? col_nx[7:0] : {1'b0, col_nx[6:0]};
    pbit     = fq.eight ? col_nx[8] : col_nx[7];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      s3   <= 1'b1;
      st   <= S_IDLE;
      cnt  <= '0;
      idx  <= 4'd0;
      col  <= '0;
      fq   <= '0;
      done <= 1'b0;
      data <= 8'h00;
      perr <= 1'b0;
      ferr <= 1'b0;
    end else begin
      s1   <= rxd;
      s2   <= s1;
      s3   <= s2;
      done <= 1'b0;
      if (!rx_en) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (s3 && !s2) begin
            st  <= S_START;
            cnt <= '0;
            fq  <= fmt;
          end
          S_START: if (tick) begin
            if (cnt == MID) begin
              cnt <= '0;
              idx <= 4'd0;
              st  <= s2 ? S_IDLE : S_BITS;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_BITS: if (tick) begin
            if (cnt == TOP) begin
              cnt <= '0;
              col <= col_nx;
              idx <= idx + 4'd1;
              if (idx == last_idx) begin
                st   <= S_IDLE;
                done <= 1'b1;
                data <= dat_nx;
                perr <= fq.par_en && (pbit != par_of(dat_nx, fq));
                ferr <= !col_nx[stop0] || (fq.two_stop && !col_nx[stop0 + 4'd1]);
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ser_chan.sv
module ser_chan
  import ser_chan_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              baud_tick,
  input  logic              rxd,
  output logic              txd,
  output logic              rts_n,
  output logic              irq
);
  line_fmt_t  fmt;
  logic       rx_en, tx_en, tdr_full, tx_take, tx_busy;
  logic [7:0] tdr, stat, rdr_val, rx_data;
  logic       rx_done, rx_perr, rx_ferr, err_any;

  ser_chan_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fmt(fmt), .rx_en(rx_en),
    .tx_en(tx_en), .rts_n(rts_n), .irq(irq), .tdr(tdr), .tdr_full(tdr_full),
    .tx_take(tx_take), .rx_done(rx_done), .rx_data(rx_data), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .stat(stat), .rdr(rdr_val), .err_any(err_any)
  );

  ser_chan_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(baud_tick), .tx_en(tx_en), .fmt(fmt), .tdr(tdr),
    .tdr_full(tdr_full), .take(tx_take), .busy(tx_busy), .txd(txd)
  );

  ser_chan_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick(baud_tick), .rxd(rxd), .rx_en(rx_en), .fmt(fmt),
    .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
  );
endmodule

// File: rtl/ser_chan_chk.sv
module ser_chan_chk
  import ser_chan_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic              irq,
  input logic              txd,
  input logic              rx_done,
  input logic              err_any,
  input logic [7:0]        stat,
  input logic [7:0]        rdr,
  input logic              tx_busy
);
  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (stat[3] && stat[7]) |=> irq);
  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(stat[3] && stat[7]) |=> !irq);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (err_any && rx_done) |=> $stable(rdr));
  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_CA) && !bus_wdata[3] && !rx_done) |=> (stat[6:4] == 3'b000));
  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_done && stat[7] && !err_any) |=> (stat[6] && $stable(rdr)));
  // R4
  tdr_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_TD)) |=> !stat[1]);
  // R3
  tx_idle_line_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd);
endmodule

bind ser_chan ser_chan_chk u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .irq(irq), .txd(txd), .rx_done(rx_done), .err_any(err_any), .stat(stat),
  .rdr(rdr_val), .tx_busy(tx_busy)
);

// File: tb/test_ser_chan.sv
module test_ser_chan;
  localparam int BIT = 64; // 16 ticks of 4 clocks

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = 4'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       baud_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       txd, rts_n, irq;
  logic [1:0] tc = 2'd0;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit mon_busy = 1'b0;

  typedef struct {
    logic [11:0] bits;
    int          len;
  } frame_t;

  frame_t sb[$];

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      tc <= 2'd0;
      baud_tick <= 1'b0;
    end else begin
      tc <= tc + 2'd1;
      baud_tick <= (tc == 2'd3);
    end
  end

  ser_chan i_ser_chan (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .baud_tick(baud_tick),
    .rxd(rxd), .txd(txd), .rts_n(rts_n), .irq(irq)
  );

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic frame_t mk(input logic [7:0] d, input bit eight, input bit pen, input bit odd, input bit two);
    frame_t f;
    int n;
    int ones;
    f.bits = '1;
    f.bits[0] = 1'b0;
    n = 1;
    ones = 0;
    for (int i = 0; i < (eight ? 8 : 7); i++) begin
      f.bits[n] = d[i];
      ones += int'(d[i]);
      n++;
    end
    if (pen) begin
      f.bits[n] = odd ? ~ones[0] : ones[0];
      n++;
    end
    n += two ? 2 : 1;
    f.len = n;
    return f;
  endfunction

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // driver: push the expected line bits, then hand the byte to the design
  task automatic tx_send(input logic [7:0] d, input bit eight, input bit pen, input bit odd, input bit two);
    logic [7:0] s;
    sb.push_back(mk(d, eight, pen, odd, two));
    do bus_read(4'd4, s); while (!s[1]);
    bus_write(4'd6, d);
  endtask

  task automatic tx_drain();
    while (sb.size() != 0 || mon_busy) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic rx_send(input logic [7:0] d, input bit eight, input bit pen, input bit odd,
                         input bit two, input bit bad_par, input bit bad_stop);
    frame_t f;
    int nd;
    f = mk(d, eight, pen, odd, two);
    nd = eight ? 8 : 7;
    if (bad_par) f.bits[1 + nd] = ~f.bits[1 + nd];
    if (bad_stop) f.bits[1 + nd + (pen ? 1 : 0)] = 1'b0;
    for (int i = 0; i < f.len; i++) begin
      rxd = f.bits[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  // monitor: decode each frame on txd and compare with the scoreboard head
  initial begin
    frame_t e;
    logic [11:0] got;
    forever begin
      @(negedge clk);
      if (!rst && txd === 1'b0) begin
        mon_busy = 1'b1;
        got = '1;
        repeat (31) @(negedge clk);
        got[0] = txd;
        if (sb.size() == 0) begin
          check("R3", "frame with empty scoreboard", 16'd1, 16'd0);
        end else begin
          e = sb.pop_front();
          for (int i = 1; i < e.len; i++) begin
            repeat (BIT) @(negedge clk);
            got[i] = txd;
          end
          check("R3", "tx frame bits", {4'd0, got}, {4'd0, e.bits});
        end
        mon_busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset values and decode
    bus_read(4'd0, r); check("R1", "ctrl A reset", r, 8'h64);
    bus_read(4'd2, r); check("R1", "ctrl B reset", r, 8'h00);
    bus_read(4'd4, r); check("R2", "status reset", r, 8'h02);
    bus_read(4'd1, r); check("R1", "unused offset", r, 8'h00);
    check("R3", "txd idle", txd, 1'b1);
    check("R11", "rts_n reset", rts_n, 1'b0);
    check("R10", "irq reset", irq, 1'b0);

    // R2 only enable bits writable
    bus_write(4'd4, 8'hFF);
    bus_read(4'd4, r); check("R2", "status after all-ones write", r, 8'h0B);
    bus_write(4'd4, 8'h00);
    bus_write(4'd3, 8'hAA);
    bus_read(4'd3, r); check("R1", "unused offset ignores write", r, 8'h00);

    // R3 8N1, back to back; R4 holding register busy
    tx_send(8'hA5, 1, 0, 0, 0);
    tx_send(8'h3C, 1, 0, 0, 0);
    bus_read(4'd4, r); check("R4", "tdre low while shifter busy", r[1], 1'b0);
    tx_drain();
    bus_read(4'd4, r); check("R4", "tdre back after drain", r[1], 1'b1);

    // R3 7 data bits, even parity, two stops
    bus_write(4'd0, 8'h63);
    tx_send(8'h55, 0, 1, 0, 1);
    tx_send(8'hFF, 0, 1, 0, 1);
    tx_drain();
    // R3 8 data bits, odd parity, one stop
    bus_write(4'd0, 8'h66);
    bus_write(4'd2, 8'h10);
    tx_send(8'h81, 1, 1, 1, 0);
    tx_drain();
    bus_write(4'd2, 8'h00);

    // R4 transmitter disabled holds the byte
    bus_write(4'd0, 8'h44);
    sb.push_back(mk(8'h5A, 1, 0, 0, 0));
    bus_write(4'd6, 8'h5A);
    repeat (300) @(negedge clk);
    check("R4", "txd high while disabled", txd, 1'b1);
    bus_read(4'd4, r); check("R4", "tdre low while disabled", r[1], 1'b0);
    bus_write(4'd0, 8'h64);
    tx_drain();
    check("R4", "held byte sent after enable", sb.size(), 16'd0);

    // R11
    bus_write(4'd0, 8'h74);
    check("R11", "rts_n with bit4 set", rts_n, 1'b1);
    bus_write(4'd0, 8'h64);
    check("R11", "rts_n with bit4 clear", rts_n, 1'b0);

    // R5 plain receive
    rx_send(8'h96, 1, 0, 0, 0, 0, 0);
    bus_read(4'd4, r); check("R5", "status after frame", r, 8'h82);
    bus_read(4'd8, r); check("R5", "received byte", r, 8'h96);
    bus_read(4'd4, r); check("R5", "full cleared by read", r, 8'h02);

    // R10 interrupt
    bus_write(4'd4, 8'h08);
    check("R10", "irq low with enable only", irq, 1'b0);
    rx_send(8'h11, 1, 0, 0, 0, 0, 0);
    check("R10", "irq with data and enable", irq, 1'b1);
    bus_read(4'd8, r); check("R5", "second byte", r, 8'h11);
    repeat (2) @(negedge clk);
    check("R10", "irq drops after read", irq, 1'b0);
    bus_write(4'd4, 8'h00);

    // R5 R6 seven bits, even parity, two stops
    bus_write(4'd0, 8'h63);
    rx_send(8'hB5, 0, 1, 0, 1, 0, 0);
    bus_read(4'd4, r); check("R6", "good parity no flag", r, 8'h82);
    bus_read(4'd8, r); check("R5", "7-bit byte bit7 zero", r, 8'h35);
    rx_send(8'h4C, 0, 1, 0, 1, 1, 0);
    bus_read(4'd4, r); check("R6", "parity error flagged", r, 8'hA2);
    bus_read(4'd8, r); check("R6", "byte kept with parity error", r, 8'h4C);
    // R8 stall
    rx_send(8'h22, 0, 1, 0, 1, 0, 0);
    bus_read(4'd4, r); check("R8", "frame dropped while flagged", r, 8'h22);
    bus_read(4'd8, r); check("R8", "data unchanged while flagged", r, 8'h4C);
    // R9 bit3 set does not clear, bit3 clear does
    bus_write(4'd0, 8'h6B);
    bus_read(4'd4, r); check("R9", "write with bit3 set keeps flag", r, 8'h22);
    bus_write(4'd0, 8'h63);
    bus_read(4'd4, r); check("R9", "write with bit3 clear", r, 8'h02);
    rx_send(8'h22, 0, 1, 0, 1, 0, 0);
    bus_read(4'd8, r); check("R8", "receive resumes after clear", r, 8'h22);

    // R6 framing error
    bus_write(4'd0, 8'h64);
    rx_send(8'hC3, 1, 0, 0, 0, 0, 1);
    bus_read(4'd4, r); check("R6", "framing error flagged", r, 8'h92);
    bus_write(4'd0, 8'h64);
    bus_read(4'd4, r); check("R9", "framing flag cleared", r, 8'h82);
    bus_read(4'd8, r); check("R6", "byte kept with framing error", r, 8'hC3);

    // R7 overrun
    rx_send(8'h01, 1, 0, 0, 0, 0, 0);
    rx_send(8'h02, 1, 0, 0, 0, 0, 0);
    bus_read(4'd4, r); check("R7", "overrun flagged", r, 8'hC2);
    bus_read(4'd8, r); check("R7", "first byte kept", r, 8'h01);
    bus_write(4'd0, 8'h64);
    bus_read(4'd4, r); check("R9", "overrun cleared", r, 8'h02);

    // R12 receiver disabled
    bus_write(4'd0, 8'h24);
    rx_send(8'h77, 1, 0, 0, 0, 0, 0);
    bus_read(4'd4, r); check("R12", "no data while disabled", r, 8'h02);
    bus_write(4'd0, 8'h64);
    rx_send(8'h78, 1, 0, 0, 0, 0, 0);
    bus_read(4'd8, r); check("R12", "receive after enable", r, 8'h78);

    check("R3", "scoreboard empty", sb.size(), 16'd0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule